// File: doc/BRIEF.md
# Inbound Mailbox Register Block

This block is a word-wide, register-mapped mailbox through which peripherals hand response words to a host processor. Peripherals push 32-bit words into a 32-entry first-in first-out store. The host drains that store with ordinary bus reads. It can look at the oldest word without consuming it, poll a status word that carries full and empty flags, and arm a single interrupt line that stays asserted while words are waiting.

The host side is a simple single-cycle register port. An access is taken only when all four byte lanes are enabled and the offset is word aligned. Only the low eight address bits take part in decode. Read data is returned combinationally in the cycle of the request, and any removal takes effect at the following clock edge. The block also passes through, at a fixed offset, the status word of a companion outbound mailbox that lives elsewhere.

Top module: `mbox_regs`

## Requirements
- R1: After reset the count is zero, the status word reads 0x40000000, the config word reads 0, the interrupt is low, and every slot holds the sentinel 0x0000000F.
- R2: Words leave through the pop window (offsets 0x80, 0x84, 0x88, 0x8C) in the order they were pushed. Each such read returns the oldest word and removes it.
- R3: Status bit 31 is set exactly when 32 words are held, and `push_ready` is low then. A push offered while full is discarded.
- R4: A pop-window read while empty returns 0x0000000F and leaves the count at zero. Status bit 30 is set exactly when no word is held.
- R5: A read at offset 0x90 returns the oldest word and removes nothing.
- R6: A write to offset 0x9C changes only config bit 0, the interrupt enable. Config bit 4 reads 1 whenever the store is not empty, and every other config bit reads 0.
- R7: `irq` is a registered output. Following each clock edge it equals config bit 0 AND not-empty, as both stand after that edge.
- R8: Address bits above bit 7 are ignored, so 0x180 and 0x280 decode as 0x80.
- R9: An access with `req_be` other than 4'hF, or with address bits 1:0 non-zero, is ignored: it returns 0, removes nothing and writes nothing.
- R10: A read at offset 0xB8 returns the `ob_status` input unchanged.
- R11: A read at an undecoded offset returns 0. A write to any offset other than 0x9C, including the pop window, changes nothing.
- R12: Once the last word is popped, a read at offset 0x90 returns 0x0000000F.
- R13: A push and a pop in the same cycle return the oldest word, keep the count unchanged and place the pushed word last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Peripheral offers a word this cycle |
| push_data | input | 32 | Word offered by the peripheral |
| push_ready | output | 1 | High while the store has room |
| req_valid | input | 1 | Host access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Host byte address; low 8 bits decoded |
| req_be | input | 4 | Byte enables; must be 4'hF to be accepted |
| req_wdata | input | 32 | Host write data |
| rd_data | output | 32 | Read data, valid in the cycle of the read |
| ob_status | input | 32 | Status word of the outbound mailbox |
| irq | output | 1 | Data-available interrupt to the host |

## Verification
The store is filled word by word from empty to full, and the flags are checked after every push. An extra push at full then shows whether rejection works at the boundary. Draining goes through all four pop-window offsets, with upper address bits varied, which separates order errors from decode and aliasing errors. The interrupt is compared with enable AND non-empty across the enable write and across the final pop. Partial-lane, misaligned and undecoded accesses are interleaved with held data, so that any unwanted side effect shows up in the words popped afterwards. A simultaneous push and pop, an empty pop and a reset with data held cover the remaining edge cases.

// File: rtl/mbox_pkg.sv
// Shared constants and types for the inbound mailbox register block.
// Assumes a 32-bit register port whose decode uses only the low 8 address bits.
package mbox_pkg;
    localparam logic [31:0] MBOX_EMPTY_WORD = 32'h0000_000F;

    localparam logic [3:0] OFF_POP_NIB = 4'h8;   // 0x80..0x8C pop window
    localparam logic [7:0] OFF_PEEK    = 8'h90;
    localparam logic [7:0] OFF_STAT    = 8'h98;
    localparam logic [7:0] OFF_CFG     = 8'h9C;
    localparam logic [7:0] OFF_OBSTAT  = 8'hB8;

    localparam int STAT_FULL_BIT  = 31;
    localparam int STAT_EMPTY_BIT = 30;
    localparam int CFG_EN_BIT     = 0;
    localparam int CFG_PEND_BIT   = 4;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_POP,
        SEL_PEEK,
        SEL_STAT,
        SEL_CFG,
        SEL_OBSTAT
    } reg_sel_e;
endpackage

// File: rtl/mbox_decode.sv
// Register decoder: qualifies a host access (all lanes, word aligned) and
// maps the low 8 address bits to a register select.
// Assumes ADDR_W >= 8; upper address bits are deliberately not decoded.
module mbox_decode
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be,
    output reg_sel_e          rd_sel,
    output logic              pop_req,
    output logic              cfg_wr
);
    logic [7:0] offs;
    logic       acc_ok;
    reg_sel_e   sel;

    // Qualify the access and pick the addressed register.
    always_comb begin
        offs   = req_addr[7:0];
        acc_ok = req_valid && (req_be == 4'hF) && (offs[1:0] == 2'b00);
        if (offs[7:4] == OFF_POP_NIB)  sel = SEL_POP;
        else if (offs == OFF_PEEK)     sel = SEL_PEEK;
        else if (offs == OFF_STAT)     sel = SEL_STAT;
        else if (offs == OFF_CFG)      sel = SEL_CFG;
        else if (offs == OFF_OBSTAT)   sel = SEL_OBSTAT;
        else                           sel = SEL_NONE;
    end

    // Split the qualified access into read select and side effects.
    always_comb begin
        rd_sel  = (acc_ok && !req_write) ? sel : SEL_NONE;
        pop_req = acc_ok && !req_write && (sel == SEL_POP);
        cfg_wr  = acc_ok && req_write && (sel == SEL_CFG);
    end

    p_pop_is_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req |-> (req_valid && !req_write && req_be == 4'hF));
    p_cfg_wr_full_lanes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |-> (req_be == 4'hF && req_addr[1:0] == 2'b00));
endmodule

// File: rtl/mbox_fifo.sv
// Shift-down word store: slot 0 is always the oldest word. Free slots hold
// the sentinel, so slot 0 reads the sentinel whenever the store is empty.
// Assumes push is accepted only when not full; pop only when not empty.
module mbox_fifo
    import mbox_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [DW-1:0]    push_data,
    input  logic             pop_req,
    output logic [DW-1:0]    head,
    output logic             full,
    output logic             empty,
    output logic             push_ok,
    output logic             nonempty_next
);
    localparam logic [DW-1:0] SENT = DW'(MBOX_EMPTY_WORD);

    logic [DW-1:0]    slot_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic             pop_ok;

    // Flags and accepted operations for this cycle.
    always_comb begin
        full          = (cnt_q == CNT_W'(DEPTH));
        empty         = (cnt_q == '0);
        push_ok       = push_valid && !full;
        pop_ok        = pop_req && !empty;
        cnt_next      = cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
        nonempty_next = (cnt_next != '0);
        head          = slot_q[0];
    end

    // Occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_next;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [DW-1:0] above;
        if (i == DEPTH - 1) begin : g_top
            assign above = SENT;
        end else begin : g_mid
            assign above = slot_q[i+1];
        end

        // Per-slot update: shift on pop, capture push at the tail.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[i] <= SENT;
            end else if (pop_ok) begin
                if (push_ok && (CNT_W'(i) == cnt_q - 1'b1)) slot_q[i] <= push_data;
                else                                        slot_q[i] <= above;
            end else if (push_ok && (CNT_W'(i) == cnt_q)) begin
                slot_q[i] <= push_data;
            end
        end
    end

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));
    p_full_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop_req) |=> full);
    p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !push_valid) |=> empty);
    p_head_sentinel_r12: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (head == SENT));
    p_flags_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
endmodule

// File: rtl/mbox_irq.sv
// Interrupt enable register and registered data-available interrupt.
// Assumes nonempty_next reflects the store occupancy after this edge.
module mbox_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic en_wdata,
    input  logic nonempty_next,
    input  logic nonempty_now,
    output logic en_q,
    output logic irq
);
    logic en_next;

    // Only the enable bit is writable.
    always_comb en_next = cfg_wr ? en_wdata : en_q;

    // Enable register and interrupt flop, updated on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            irq  <= 1'b0;
        end else begin
            en_q <= en_next;
            irq  <= en_next && nonempty_next;
        end
    end

    p_irq_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (en_q && nonempty_now));
    p_cfg_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (en_q == $past(en_wdata)));
endmodule

// File: rtl/mbox_regs.sv
// Inbound mailbox register block top: peripheral push port, host register
// port with pop window, peek, status, config and outbound-status registers.
// Assumes single-cycle host accesses; read data is combinational.
module mbox_regs
    import mbox_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [31:0]       push_data,
    output logic              push_ready,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rd_data,
    input  logic [31:0]       ob_status,
    output logic              irq
);
    localparam int DW = 32;

    reg_sel_e      rd_sel;
    logic          pop_req;
    logic          cfg_wr;
    logic [DW-1:0] head;
    logic          full;
    logic          empty;
    logic          push_ok;
    logic          nonempty_next;
    logic          en_q;
    logic [DW-1:0] stat_word;
    logic [DW-1:0] cfg_word;

    mbox_decode #(.ADDR_W(ADDR_W)) i_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_be   (req_be),
        .rd_sel   (rd_sel),
        .pop_req  (pop_req),
        .cfg_wr   (cfg_wr)
    );

    mbox_fifo #(.DEPTH(DEPTH), .DW(DW)) i_fifo (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_valid   (push_valid),
        .push_data    (push_data),
        .pop_req      (pop_req),
        .head         (head),
        .full         (full),
        .empty        (empty),
        .push_ok      (push_ok),
        .nonempty_next(nonempty_next)
    );

    mbox_irq i_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .en_wdata     (req_wdata[CFG_EN_BIT]),
        .nonempty_next(nonempty_next),
        .nonempty_now (!empty),
        .en_q         (en_q),
        .irq          (irq)
    );

    // Assemble the status and config words.
    always_comb begin
        stat_word                 = '0;
        stat_word[STAT_FULL_BIT]  = full;
        stat_word[STAT_EMPTY_BIT] = empty;
        cfg_word                  = '0;
        cfg_word[CFG_EN_BIT]      = en_q;
        cfg_word[CFG_PEND_BIT]    = !empty;
        push_ready                = !full;
    end

    // Read-data multiplexer.
    always_comb begin
        case (rd_sel)
            SEL_POP, SEL_PEEK: rd_data = head;
            SEL_STAT:          rd_data = stat_word;
            SEL_CFG:           rd_data = cfg_word;
            SEL_OBSTAT:        rd_data = ob_status;
            default:           rd_data = '0;
        endcase
    end

    p_push_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !push_ready) |-> !push_ok);
    p_empty_pop_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty) |-> (rd_data == MBOX_EMPTY_WORD));
endmodule

// File: tb/test_mbox_regs.sv
`timescale 1ns/100ps
module test_mbox_regs;
    localparam int DEPTH  = 32;
    localparam int ADDR_W = 12;
    localparam logic [31:0] SENT = 32'h0000_000F;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              push_valid;
    logic [31:0]       push_data;
    logic              push_ready;
    logic              req_valid;
    logic              req_write;
    logic [ADDR_W-1:0] req_addr;
    logic [3:0]        req_be;
    logic [31:0]       req_wdata;
    logic [31:0]       rd_data;
    logic [31:0]       ob_status;
    logic              irq;

    int total = 0;
    int bad   = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    mbox_regs #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_mbox_regs (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata), .rd_data(rd_data),
        .ob_status(ob_status), .irq(irq)
    );

    function automatic logic [31:0] pat(input int k);
        return 32'hC0DE_0000 + 32'(k) * 32'h0001_0003;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, sample read data, apply at posedge.
    task automatic cyc(input logic pv, input logic [31:0] pd, input logic rq,
                       input logic wr, input logic [ADDR_W-1:0] a,
                       input logic [3:0] be, input logic [31:0] wd,
                       output logic [31:0] rd);
        @(negedge clk);
        push_valid = pv; push_data = pd;
        req_valid = rq; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
        #1 rd = rd_data;
        @(posedge clk);
        #1;
        push_valid = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        cyc(1'b0, '0, 1'b1, 1'b0, a, 4'hF, '0, d);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [3:0] be, input logic [31:0] d);
        logic [31:0] dummy;
        cyc(1'b0, '0, 1'b1, 1'b1, a, be, d, dummy);
    endtask

    task automatic push(input logic [31:0] d);
        logic [31:0] dummy;
        cyc(1'b1, d, 1'b0, 1'b0, '0, 4'hF, '0, dummy);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; push_valid = 1'b0; push_data = '0;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_be = 4'hF;
        req_wdata = '0; ob_status = 32'h1234_5678;
        do_reset();

        // R1: reset state
        check("R1 irq", {31'b0, irq}, 32'd0);
        rd(12'h098, rv); check("R1 status", rv, 32'h4000_0000);
        rd(12'h09C, rv); check("R1 config", rv, 32'h0);
        rd(12'h090, rv); check("R1 peek", rv, SENT);

        // R3: fill to full, check flags after every push
        for (int k = 0; k < DEPTH; k++) begin
            push(pat(k));
            rd(12'h098, rv);
            check("R3 status during fill", rv, (k == DEPTH - 1) ? 32'h8000_0000 : 32'h0);
            check("R7 irq disabled", {31'b0, irq}, 32'd0);
        end
        check("R3 push_ready at full", {31'b0, push_ready}, 32'd0);
        push(32'hDEAD_BEEF);
        rd(12'h098, rv); check("R3 still full", rv, 32'h8000_0000);

        // R5: peek does not remove
        rd(12'h090, rv); check("R5 peek", rv, pat(0));
        rd(12'h090, rv); check("R5 peek again", rv, pat(0));

        // R6, R7: enable write sets only bit 0
        wr(12'h09C, 4'hF, 32'hFFFF_FFFF);
        check("R7 irq enabled", {31'b0, irq}, 32'd1);
        rd(12'h09C, rv); check("R6 config", rv, 32'h0000_0011);

        // R9: partial lanes and misaligned ignored
        wr(12'h09C, 4'h3, 32'h0);
        rd(12'h09C, rv); check("R9 partial write", rv, 32'h0000_0011);
        wr(12'h09E, 4'hF, 32'h0);
        rd(12'h09C, rv); check("R9 misaligned write", rv, 32'h0000_0011);
        cyc(1'b0, '0, 1'b1, 1'b0, 12'h080, 4'h7, '0, rv);
        check("R9 partial read data", rv, 32'h0);
        rd(12'h090, rv); check("R9 partial read no pop", rv, pat(0));

        // R2, R8: drain through all window offsets with aliasing
        for (int k = 0; k < DEPTH; k++) begin
            rd(ADDR_W'(12'h080 + 4 * (k % 4) + 12'h100 * (k % 3)), rv);
            check("R2 R8 pop order", rv, pat(k));
        end
        check("R7 irq after drain", {31'b0, irq}, 32'd0);

        // R4, R12: empty behaviour
        rd(12'h090, rv); check("R12 peek empty", rv, SENT);
        rd(12'h084, rv); check("R4 pop empty", rv, SENT);
        rd(12'h098, rv); check("R4 still empty", rv, 32'h4000_0000);
        rd(12'h09C, rv); check("R6 no pending", rv, 32'h0000_0001);

        // R10: outbound status pass-through
        ob_status = 32'h8000_00A5;
        rd(12'h0B8, rv); check("R10 ob status", rv, 32'h8000_00A5);
        rd(12'h3B8, rv); check("R10 ob status alias", rv, 32'h8000_00A5);

        // R11: undecoded accesses
        push(32'h1111_0001); push(32'h2222_0002);
        rd(12'h094, rv); check("R11 undecoded read", rv, 32'h0);
        rd(12'h0A0, rv); check("R11 undecoded read", rv, 32'h0);
        wr(12'h080, 4'hF, 32'h0);
        wr(12'h090, 4'hF, 32'h0);
        wr(12'h098, 4'hF, 32'hFFFF_FFFF);
        wr(12'h0FC, 4'hF, 32'h0);
        rd(12'h098, rv); check("R11 status unchanged", rv, 32'h0);
        check("R7 irq with data", {31'b0, irq}, 32'd1);

        // R13: simultaneous push and pop
        cyc(1'b1, 32'h3333_0003, 1'b1, 1'b0, 12'h088, 4'hF, '0, rv);
        check("R13 pop data", rv, 32'h1111_0001);
        rd(12'h080, rv); check("R13 second", rv, 32'h2222_0002);
        rd(12'h080, rv); check("R13 pushed last", rv, 32'h3333_0003);
        rd(12'h098, rv); check("R13 empty after", rv, 32'h4000_0000);

        // R1: reset with data held
        push(32'h4444_0004);
        do_reset();
        @(negedge clk);
        check("R1 irq after reset", {31'b0, irq}, 32'd0);
        rd(12'h090, rv); check("R1 refill peek", rv, SENT);
        rd(12'h09C, rv); check("R1 config cleared", rv, 32'h0);
        rd(12'h098, rv); check("R1 status empty", rv, 32'h4000_0000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule